// File: doc/BRIEF.md
# Shared-Timer Input Debouncer

This block filters 32 raw input lines against contact bounce and glitches. Three programmable stability periods, counted in clock cycles, form a small pool that every line draws from. Each line picks one timer, or bypass, through a 2-bit code. The code's two bits are held in two separate select words, one bit of each line in each word.

A filtered line copies its raw input only after the raw value has stayed unchanged for the chosen timer's number of clock edges. A bypassed line follows its raw input one clock later. Several lines may point at the same timer, and each line still keeps its own stability count. Rewriting a line's code, or rewriting the period of the timer a line uses, starts that line's count again. This keeps a half-elapsed window from being judged against a period it was not started under.

Software owns the policy: it decides which lines share a timer and how a time maps to cycles. The block only provides word-wide register writes and the filtering.

Top module: `shared_debounce`

## Requirements
- R1: While reset is asserted, and until the first clock edge after release, each filtered output equals its raw input. Reset clears both select words and all three periods, so every line starts in bypass.
- R2: A line whose code is 0 presents its raw input one clock edge later: the output has not yet changed before that edge and equals the raw value after it.
- R3: A line's code is {bit i of the upper-select word at address 0x00, bit i of the lower-select word at address 0x04}. Codes 1, 2 and 3 use the period words at 0x50, 0x54 and 0x58.
- R4: With a selected period P of 2 or more, a filtered output takes a new raw value at the P-th clock edge during which that value has been held. A value held for fewer edges leaves the output unchanged.
- R5: A selected period of 0 or 1 updates the output at the first clock edge that samples the new raw value.
- R6: Lines that select the same timer keep independent counts, and lines on different timers update at their own periods when stimulated together.
- R7: A change of a line's code restarts that line's count, which then runs against the new period.
- R8: A write to a period word restarts the count of every line using that timer, even if the value written is unchanged. Lines on other timers are not affected.
- R9: Writes to addresses other than 0x00, 0x04, 0x50, 0x54 and 0x58 change no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| pin_raw | input | 32 | Raw input lines |
| pin_clean | output | 32 | Filtered input lines |

## Verification
Two things can meet in one cycle: a configuration write and a raw input transition that is midway through its stability window. The bench starts a transition on one line. Two edges later it rewrites either that line's code or, with the same value, the period of its timer, while a second line on another timer is counting at the same time. It judges the result by the exact edge on which each output moves: the restarted line must move late, counted from the write, and the other line must move on its own undisturbed schedule.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  localparam int unsigned NUM_PINS   = 32;
  localparam int unsigned PER_W      = 32;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned NUM_TIMERS = 3;
  localparam int unsigned CODE_W     = 2;

  localparam int unsigned ADDR_SEL_HI   = 'h00;
  localparam int unsigned ADDR_SEL_LO   = 'h04;
  localparam int unsigned ADDR_PER_BASE = 'h50;
  localparam int unsigned ADDR_STEP     = 4;
endpackage

// File: rtl/sdb_cfg_regs.sv
module sdb_cfg_regs
  import sdb_pkg::*;
#(
  parameter int unsigned N_PINS = NUM_PINS,
  parameter int unsigned P_W    = PER_W,
  parameter int unsigned N_TMR  = NUM_TIMERS,
  parameter int unsigned A_W    = ADDR_W,
  parameter int unsigned D_W    = DATA_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [A_W-1:0]              addr,
  input  logic [D_W-1:0]              wdata,
  output logic [N_PINS-1:0]           sel_hi,
  output logic [N_PINS-1:0]           sel_lo,
  output logic [N_TMR-1:0][P_W-1:0]   period,
  output logic [N_TMR-1:0]            per_chg
);
  logic [N_PINS-1:0]         sel_hi_q, sel_hi_d;
  logic [N_PINS-1:0]         sel_lo_q, sel_lo_d;
  logic [N_TMR-1:0][P_W-1:0] per_q, per_d;
  logic [N_TMR-1:0]          chg_q, chg_d;
  logic                      hit_any;

  always_comb begin
    sel_hi_d = sel_hi_q;
    sel_lo_d = sel_lo_q;
    per_d    = per_q;
    chg_d    = '0;
    hit_any  = 1'b0;
    if (we && addr == A_W'(ADDR_SEL_HI)) begin
      sel_hi_d = wdata[N_PINS-1:0];
      hit_any  = 1'b1;
    end
    if (we && addr == A_W'(ADDR_SEL_LO)) begin
      sel_lo_d = wdata[N_PINS-1:0];
      hit_any  = 1'b1;
    end
    for (int t = 0; t < int'(N_TMR); t++) begin
      if (we && addr == A_W'(ADDR_PER_BASE + ADDR_STEP * t)) begin
        per_d[t] = wdata[P_W-1:0];
        chg_d[t] = 1'b1;
        hit_any  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_hi_q <= '0;
      sel_lo_q <= '0;
      per_q    <= '0;
      chg_q    <= '0;
    end else begin
      sel_hi_q <= sel_hi_d;
      sel_lo_q <= sel_lo_d;
      per_q    <= per_d;
      chg_q    <= chg_d;
    end
  end

  assign sel_hi  = sel_hi_q;
  assign sel_lo  = sel_lo_q;
  assign period  = per_q;
  assign per_chg = chg_q;

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !hit_any) |=> ($stable(sel_hi_q) && $stable(sel_lo_q) && $stable(per_q)));

  // R3
  upper_select_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_W'(ADDR_SEL_HI)) |=> (sel_hi_q == $past(wdata[N_PINS-1:0])));

  // R8
  period_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg_q));
endmodule

// File: rtl/sdb_pin_filter.sv
module sdb_pin_filter
  import sdb_pkg::*;
#(
  parameter int unsigned P_W   = PER_W,
  parameter int unsigned N_TMR = NUM_TIMERS,
  parameter int unsigned C_W   = CODE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       raw,
  input  logic [C_W-1:0]             code,
  input  logic [N_TMR-1:0][P_W-1:0]  period,
  input  logic [N_TMR-1:0]           per_chg,
  output logic                       clean
);
  localparam logic [P_W-1:0] RUN_ONE = P_W'(1);
  localparam logic [P_W-1:0] RUN_MAX = '1;

  logic           seeded_q, seeded_d;
  logic           raw_q, raw_d;
  logic           out_q, out_d;
  logic [C_W-1:0] code_q, code_d;
  logic [P_W-1:0] run_q, run_d;

  logic           bypass;
  logic [C_W-1:0] tidx;
  logic [P_W-1:0] per_sel;
  logic           chg_sel;
  logic           restart;

  always_comb begin
    bypass  = (code == '0) || (int'(code) > int'(N_TMR));
    tidx    = code - C_W'(1);
    per_sel = bypass ? '0 : period[tidx];
    chg_sel = !bypass && per_chg[tidx];
    restart = (raw != raw_q) || (code != code_q) || chg_sel;

    if (restart)              run_d = RUN_ONE;
    else if (run_q == RUN_MAX) run_d = run_q;
    else                      run_d = run_q + RUN_ONE;

    out_d = out_q;
    if (!seeded_q || bypass || run_d >= per_sel) out_d = raw;

    raw_d    = raw;
    code_d   = code;
    seeded_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seeded_q <= 1'b0;
      raw_q    <= 1'b0;
      out_q    <= 1'b0;
      code_q   <= '0;
      run_q    <= '0;
    end else begin
      seeded_q <= seeded_d;
      raw_q    <= raw_d;
      out_q    <= out_d;
      code_q   <= code_d;
      run_q    <= run_d;
    end
  end

  assign clean = seeded_q ? out_q : raw;

  // R2
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seeded_q && bypass) |=> (clean == $past(raw)));

  // R4
  short_run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seeded_q && !bypass && per_sel > RUN_ONE && raw != raw_q) |=> $stable(clean));

  // R5
  short_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seeded_q && !bypass && per_sel <= RUN_ONE) |=> (clean == $past(raw)));

  // R7
  code_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seeded_q && !bypass && per_sel > RUN_ONE && code != code_q) |=> $stable(clean));

  // R8
  period_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seeded_q && chg_sel && per_sel > RUN_ONE) |=> $stable(clean));
endmodule

// File: rtl/shared_debounce.sv
module shared_debounce
  import sdb_pkg::*;
#(
  parameter int unsigned N_PINS = NUM_PINS,
  parameter int unsigned P_W    = PER_W,
  parameter int unsigned N_TMR  = NUM_TIMERS,
  parameter int unsigned A_W    = ADDR_W,
  parameter int unsigned D_W    = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [A_W-1:0]    cfg_addr,
  input  logic [D_W-1:0]    cfg_wdata,
  input  logic [N_PINS-1:0] pin_raw,
  output logic [N_PINS-1:0] pin_clean
);
  logic                      rst_meta_q, rst_sync_q;
  logic [N_PINS-1:0]         sel_hi, sel_lo;
  logic [N_TMR-1:0][P_W-1:0] period;
  logic [N_TMR-1:0]          per_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sdb_cfg_regs #(
    .N_PINS(N_PINS), .P_W(P_W), .N_TMR(N_TMR), .A_W(A_W), .D_W(D_W)
  ) cfg_i (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .sel_hi (sel_hi),
    .sel_lo (sel_lo),
    .period (period),
    .per_chg(per_chg)
  );

  for (genvar i = 0; i < int'(N_PINS); i++) begin : g_pin
    sdb_pin_filter #(
      .P_W(P_W), .N_TMR(N_TMR), .C_W(CODE_W)
    ) filt_i (
      .clk    (clk),
      .rst_n  (rst_sync_q),
      .raw    (pin_raw[i]),
      .code   ({sel_hi[i], sel_lo[i]}),
      .period (period),
      .per_chg(per_chg),
      .clean  (pin_clean[i])
    );
  end
endmodule

// File: tb/shared_debounce_tb.sv
module shared_debounce_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 10;
  // {raw value, expected output, edges held}
  localparam logic [7:0] VEC_TAB [0:N_VEC-1] = '{
    {1'b1, 1'b1, 6'd4}, {1'b0, 1'b1, 6'd3}, {1'b1, 1'b1, 6'd2},
    {1'b0, 1'b0, 6'd5}, {1'b1, 1'b0, 6'd1}, {1'b0, 1'b0, 6'd4},
    {1'b1, 1'b0, 6'd3}, {1'b0, 1'b0, 6'd2}, {1'b1, 1'b1, 6'd6},
    {1'b0, 1'b0, 6'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] pin_raw;
  logic [31:0] pin_clean;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_debounce dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pin_raw(pin_raw), .pin_clean(pin_clean)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    pin_raw = 32'hA5A5_5A5A;
    #(CLK_PERIOD * 2 + 3);
    chk(pin_clean, 32'hA5A5_5A5A, "R1 reset passthrough");
    pin_raw = 32'h1234_5678;
    #1;
    chk(pin_clean, 32'h1234_5678, "R1 reset passthrough tracks");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pin_clean, 32'h1234_5678, "R1 bypass after reset");
    pin_raw = 32'h0;
    chk(pin_clean, 32'h1234_5678, "R2 no change before edge");
    @(negedge clk);
    chk(pin_clean, 32'h0, "R2 one edge delay");

    // R3: pin0 code1 P4, pin1 code2 P0, pin2 code3 P6, pin3 code1, pin4 bypass
    cfg_write(8'h50, 32'd4);
    cfg_write(8'h54, 32'd0);
    cfg_write(8'h58, 32'd6);
    cfg_write(8'h00, 32'h6);
    cfg_write(8'h04, 32'hD);
    repeat (2) @(negedge clk);

    // R4: vector walk on pin0 with period 4
    for (int v = 0; v < N_VEC; v++) begin
      pin_raw[0] = VEC_TAB[v][7];
      repeat (int'(VEC_TAB[v][5:0])) @(negedge clk);
      chk({31'h0, pin_clean[0]}, {31'h0, VEC_TAB[v][6]}, "R4 stability window");
    end
    chk({27'h0, pin_clean[4:1]}, 32'h0, "R4 idle lines unchanged");

    // R6 / R3 / R5: lines on different timers stimulated together
    pin_raw[4:0] = 5'h1F;
    @(negedge clk);
    chk({27'h0, pin_clean[4:0]}, 32'h12, "R5 R6 edge 1");
    repeat (3) @(negedge clk);
    chk({27'h0, pin_clean[4:0]}, 32'h1B, "R6 edge 4 shared timer");
    @(negedge clk);
    chk({27'h0, pin_clean[4:0]}, 32'h1B, "R3 edge 5");
    @(negedge clk);
    chk({27'h0, pin_clean[4:0]}, 32'h1F, "R3 edge 6");

    // R7: pin3 moves from code1 (P4) to code3 (P6) mid-window
    pin_raw[3] = 1'b0;
    repeat (2) @(negedge clk);
    cfg_write(8'h00, 32'hE);
    repeat (5) @(negedge clk);
    chk({31'h0, pin_clean[3]}, 32'h1, "R7 restart delays update");
    @(negedge clk);
    chk({31'h0, pin_clean[3]}, 32'h0, "R7 update after restart");
    chk({31'h0, pin_clean[2]}, 32'h1, "R7 other line untouched");

    // R8: same-value rewrite of timer1 restarts pin0, pin3 on timer3 unaffected
    pin_raw[0] = 1'b0;
    pin_raw[3] = 1'b1;
    repeat (2) @(negedge clk);
    cfg_write(8'h50, 32'd4);
    repeat (3) @(negedge clk);
    chk({31'h0, pin_clean[0]}, 32'h1, "R8 restart delays update");
    chk({31'h0, pin_clean[3]}, 32'h1, "R8 other timer unaffected");
    @(negedge clk);
    chk({31'h0, pin_clean[0]}, 32'h0, "R8 update after restart");

    // R9: writes to unmapped addresses
    cfg_write(8'h08, 32'h0);
    cfg_write(8'h4C, 32'h0);
    cfg_write(8'h5C, 32'h0);
    pin_raw[0] = 1'b1;
    @(negedge clk);
    chk({31'h0, pin_clean[0]}, 32'h0, "R9 config kept");
    repeat (3) @(negedge clk);
    chk({31'h0, pin_clean[0]}, 32'h1, "R9 period kept");

    // R5: period 1
    cfg_write(8'h50, 32'd1);
    pin_raw[0] = 1'b0;
    @(negedge clk);
    chk({31'h0, pin_clean[0]}, 32'h0, "R5 period one");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule